// File: doc/BRIEF.md
# SIMD Byte Extract Unit

This block takes one 32-bit vector-extract instruction word and two 128-bit source values. It decodes the word and produces the byte-granular extract result one clock cycle later. The decode checks the fixed opcode bits for the encoding set chosen by `wide_fmt`. A low `wide_fmt` selects the 32-bit fixed-width set. A high `wide_fmt` selects the 16x2 wide-format set. The decode then extracts the three 5-bit register numbers, the vector size and the byte offset, and flags encodings that must raise an undefined-instruction exception.

The extract places the second operand above the first and takes a window that starts `offset` bytes up from the bottom of the first. The result therefore holds the upper bytes of the first operand followed by the lower bytes of the second. Bytes are plain 8-bit fields with no data type.

- In 64-bit mode only the low halves take part, and the 64-bit window is zero-extended to 128 bits.
- In 128-bit mode the full operands are used.

Latency is always one cycle and never depends on the data. A register file, a condition check and the write-back stage sit around the block, outside it.

The output stage is a two-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | No result is presented. |
| `ST_VALID` | A result is presented. |

| Transition | Condition |
|---|---|
| `ST_IDLE` to `ST_VALID` | `in_valid` is high. |
| `ST_VALID` to `ST_VALID` | `in_valid` is high again. |
| `ST_VALID` to `ST_IDLE` | `in_valid` is low. |

Each accepted word is classified into one of four decode kinds: `DK_NOMATCH`, `DK_UNDEF`, `DK_DWORD` or `DK_QWORD`.

Top module: `simd_bext_top`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. The latency is one cycle for every input value. While `in_valid` is low, all other outputs keep their last values.
- R2: The word matches only if the following fixed bits are correct:
  - bits 31:23 are 111100101 when `wide_fmt`=0, or 111011111 when `wide_fmt`=1;
  - bits 21:20 are 11;
  - bit 4 is 0.
  A word that is correct for the other encoding set does not match.
- R3: For a matching word, the register numbers and the size flag are reported as follows:
  - `dst_reg` = {bit 22, bits 15:12};
  - `srca_reg` = {bit 7, bits 19:16};
  - `srcb_reg` = {bit 5, bits 3:0};
  - `quad_mode` = bit 6 (1 = 128-bit operation, 0 = 64-bit operation).
- R4: In 128-bit mode a matching word is undefined when any of bits 12, 16 or 0 is 1, that is, when any register number is odd.
- R5: In 64-bit mode a matching word is undefined exactly when bit 11 (the top offset bit) is 1. Odd register numbers are allowed in this mode.
- R6: For an undefined word, `out_valid`=1, `match`=1, `undef`=1 and `result` is all zeros.
- R7: For a non-matching word, `out_valid`=1, `match`=0, `undef`=0, `quad_mode`=0, all register numbers are 0 and `result` is 0.
- R8: In 64-bit mode with offset k = bits 11:8 in 0..7, `result` = bits 63:0 of ({B[63:0], A[63:0]} >> 8k), with bits 127:64 equal to zero.
- R9: In 128-bit mode with offset k in 0..15, `result` = bits 127:0 of ({B, A} >> 8k).
- R10: An offset of 0 returns the first operand A unchanged. In 64-bit mode this is its low half, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands present |
| wide_fmt | input | 1 | Encoding set: 0 = 32-bit fixed width, 1 = 16x2 wide format |
| instr | input | 32 | Instruction word |
| src_a | input | 128 | First operand (supplies the bottom of the concatenation) |
| src_b | input | 128 | Second operand (supplies the top of the concatenation) |
| out_valid | output | 1 | Result present |
| dst_reg | output | 5 | Destination register number |
| srca_reg | output | 5 | First-source register number |
| srcb_reg | output | 5 | Second-source register number |
| quad_mode | output | 1 | 128-bit operation |
| match | output | 1 | Fixed opcode bits matched |
| undef | output | 1 | Encoding is undefined |
| result | output | 128 | Extracted bytes |

## Verification
The assertions check on every cycle that the result follows its request by exactly one cycle. They also check that undefined and non-matching results carry zero data, that a non-matching result never raises `undef`, that a 64-bit result has a zero upper half, and that a zero offset in 128-bit mode passes the first operand straight through. Only the bench scenarios can show that each byte lands in the right place. The bench sweeps every offset in both modes and both encoding sets, checking against a shift of the concatenated operands. It also covers register-field parity across all 32 values, rejection of corrupted or cross-set opcodes, and holding of the outputs while idle.

// File: rtl/simd_bext_pkg.sv
package simd_bext_pkg;

    localparam int INSTR_W = 32;
    localparam int REG_W   = 5;
    localparam int OFF_W   = 4;

    // Fixed top-of-word patterns for the two encoding sets
    localparam logic [8:0] OPC_FIXED = 9'b111100101;
    localparam logic [8:0] OPC_WIDE  = 9'b111011111;

    typedef enum logic [1:0] {
        DK_NOMATCH = 2'd0,
        DK_UNDEF   = 2'd1,
        DK_DWORD   = 2'd2,
        DK_QWORD   = 2'd3
    } dec_kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } out_state_e;

endpackage

// File: rtl/simd_bext_decode.sv
module simd_bext_decode
    import simd_bext_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               wide_fmt,
    output dec_kind_e          kind,
    output logic [REG_W-1:0]   dst_num,
    output logic [REG_W-1:0]   srca_num,
    output logic [REG_W-1:0]   srcb_num,
    output logic [OFF_W-1:0]   offset,
    output logic               quad
);

    logic       opc_ok;
    logic       fixed_ok;
    logic       odd_reg;
    logic       dword_over;
    logic [8:0] want_top;

    always_comb begin
        want_top   = wide_fmt ? OPC_WIDE : OPC_FIXED;
        fixed_ok   = (instr[21:20] == 2'b11) && !instr[4];
        opc_ok     = (instr[31:23] == want_top) && fixed_ok;
        quad       = instr[6];
        offset     = instr[11:8];
        dst_num    = {instr[22], instr[15:12]};
        srca_num   = {instr[7],  instr[19:16]};
        srcb_num   = {instr[5],  instr[3:0]};
        // quad operation needs even register pairs (r4_)
        odd_reg    = instr[12] | instr[16] | instr[0];
        // doubleword offset limited to 0..7 (r5_)
        dword_over = instr[11];

        if (!opc_ok) begin
            kind = DK_NOMATCH;
        end else if (quad ? odd_reg : dword_over) begin
            kind = DK_UNDEF;
        end else if (quad) begin
            kind = DK_QWORD;
        end else begin
            kind = DK_DWORD;
        end
    end

endmodule

// File: rtl/simd_bext_shifter.sv
module simd_bext_shifter #(
    parameter int BYTE_W    = 8,
    parameter int VEC_BYTES = 16
) (
    input  logic [BYTE_W*VEC_BYTES-1:0]   src_a,
    input  logic [BYTE_W*VEC_BYTES-1:0]   src_b,
    input  logic [$clog2(VEC_BYTES)-1:0]  offset,
    input  logic                          quad,
    output logic [BYTE_W*VEC_BYTES-1:0]   res
);

    localparam int HALF_BYTES = VEC_BYTES / 2;
    localparam int CAT_BYTES  = 2 * VEC_BYTES;
    localparam int IDX_W      = $clog2(CAT_BYTES);

    logic [BYTE_W-1:0] cat [CAT_BYTES];

    // Concatenation {B, A}: low half of each operand in doubleword mode
    for (genvar j = 0; j < CAT_BYTES; j++) begin : g_cat
        if (j < HALF_BYTES) begin : g_lo
            assign cat[j] = src_a[j*BYTE_W +: BYTE_W];
        end else if (j < VEC_BYTES) begin : g_mid
            assign cat[j] = quad ? src_a[j*BYTE_W +: BYTE_W]
                                 : src_b[(j-HALF_BYTES)*BYTE_W +: BYTE_W];
        end else begin : g_hi
            assign cat[j] = quad ? src_b[(j-VEC_BYTES)*BYTE_W +: BYTE_W]
                                 : '0;
        end
    end

    // Output byte i picks concatenation byte i + offset
    for (genvar i = 0; i < VEC_BYTES; i++) begin : g_out
        logic [IDX_W-1:0] sel;
        assign sel = IDX_W'(i) + IDX_W'(offset);
        if (i < HALF_BYTES) begin : g_low
            assign res[i*BYTE_W +: BYTE_W] = cat[sel];
        end else begin : g_up
            assign res[i*BYTE_W +: BYTE_W] = quad ? cat[sel] : '0;
        end
    end

endmodule

// File: rtl/simd_bext_top.sv
module simd_bext_top
    import simd_bext_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int VEC_BYTES = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        wide_fmt,
    input  logic [31:0]                 instr,
    input  logic [BYTE_W*VEC_BYTES-1:0] src_a,
    input  logic [BYTE_W*VEC_BYTES-1:0] src_b,
    output logic                        out_valid,
    output logic [4:0]                  dst_reg,
    output logic [4:0]                  srca_reg,
    output logic [4:0]                  srcb_reg,
    output logic                        quad_mode,
    output logic                        match,
    output logic                        undef,
    output logic [BYTE_W*VEC_BYTES-1:0] result
);

    localparam int VEC_W  = BYTE_W * VEC_BYTES;
    localparam int HALF_W = VEC_W / 2;
    localparam int SH_W   = $clog2(VEC_BYTES);

    dec_kind_e          kind;
    logic [REG_W-1:0]   d_num, a_num, b_num;
    logic [OFF_W-1:0]   off;
    logic               q_bit;
    logic [VEC_W-1:0]   shifted;
    out_state_e         state_q, state_d;

    simd_bext_decode u_decode (
        .instr    (instr),
        .wide_fmt (wide_fmt),
        .kind     (kind),
        .dst_num  (d_num),
        .srca_num (a_num),
        .srcb_num (b_num),
        .offset   (off),
        .quad     (q_bit)
    );

    simd_bext_shifter #(
        .BYTE_W    (BYTE_W),
        .VEC_BYTES (VEC_BYTES)
    ) u_shifter (
        .src_a  (src_a),
        .src_b  (src_b),
        .offset (SH_W'(off)),
        .quad   (q_bit),
        .res    (shifted)
    );

    // Output-stage state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = in_valid ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = (state_q == ST_VALID);

    // Output payload: loaded only with an accepted word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_reg   <= '0;
            srca_reg  <= '0;
            srcb_reg  <= '0;
            quad_mode <= 1'b0;
            match     <= 1'b0;
            undef     <= 1'b0;
            result    <= '0;
        end else if (in_valid) begin
            unique case (kind)
                DK_NOMATCH: begin
                    dst_reg   <= '0;
                    srca_reg  <= '0;
                    srcb_reg  <= '0;
                    quad_mode <= 1'b0;
                    match     <= 1'b0;
                    undef     <= 1'b0;
                    result    <= '0;
                end
                DK_UNDEF: begin
                    dst_reg   <= d_num;
                    srca_reg  <= a_num;
                    srcb_reg  <= b_num;
                    quad_mode <= q_bit;
                    match     <= 1'b1;
                    undef     <= 1'b1;
                    result    <= '0;
                end
                DK_DWORD, DK_QWORD: begin
                    dst_reg   <= d_num;
                    srca_reg  <= a_num;
                    srcb_reg  <= b_num;
                    quad_mode <= q_bit;
                    match     <= 1'b1;
                    undef     <= 1'b0;
                    result    <= shifted;
                end
                default: begin
                    match     <= 1'b0;
                    undef     <= 1'b0;
                    result    <= '0;
                end
            endcase
        end
    end

    // Assertions
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_undef_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && undef) |-> (match && result == '0));
    p_nomatch_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !match) |-> (!undef && result == '0));
    p_dword_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && match && !quad_mode) |-> (result[VEC_W-1:HALF_W] == '0));
    p_offset0_identity_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == DK_QWORD && off == '0) |=> (result == $past(src_a)));

endmodule

// File: tb/test_simd_bext_top.sv
module test_simd_bext_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         wide_fmt;
    logic [31:0]  instr;
    logic [127:0] src_a, src_b;
    logic         out_valid;
    logic [4:0]   dst_reg, srca_reg, srcb_reg;
    logic         quad_mode, match, undef;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    simd_bext_top i_simd_bext_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_fmt(wide_fmt),
        .instr(instr), .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .dst_reg(dst_reg), .srca_reg(srca_reg), .srcb_reg(srcb_reg),
        .quad_mode(quad_mode), .match(match), .undef(undef), .result(result)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic wide, input logic q,
                                       input logic [3:0] imm, input logic [4:0] d,
                                       input logic [4:0] n, input logic [4:0] m);
        logic [8:0] top;
        top = wide ? 9'b111011111 : 9'b111100101;
        return {top, d[4], 2'b11, n[3:0], d[3:0], imm, n[4], q, m[4], 1'b0, m[3:0]};
    endfunction

    function automatic logic [127:0] ref_ext(input logic [127:0] a, input logic [127:0] b,
                                             input logic q, input logic [3:0] imm);
        logic [255:0] w;
        logic [127:0] h;
        if (q) begin
            w = {b, a} >> (8 * imm);
            return w[127:0];
        end
        h = {b[63:0], a[63:0]} >> (8 * imm);
        return {64'h0, h[63:0]};
    endfunction

    // One transaction; outputs sampled one cycle after the accepting edge
    task automatic run(input logic wide, input logic [31:0] ins,
                       input logic [127:0] a, input logic [127:0] b,
                       input logic em, input logic eu, input logic [127:0] er,
                       input logic [4:0] ed, input logic [4:0] en, input logic [4:0] emm,
                       input logic eq, input string tag);
        @(negedge clk);
        wide_fmt = wide; instr = ins; src_a = a; src_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, {"R1 valid ", tag}, 128'(out_valid), 128'd1);
        check(match === em, {"R2 match ", tag}, 128'(match), 128'(em));
        check(undef === eu, {"undef ", tag}, 128'(undef), 128'(eu));
        check(result === er, {"result ", tag}, result, er);
        check({dst_reg, srca_reg, srcb_reg, quad_mode} === {ed, en, emm, eq},
              {"R3 fields ", tag}, 128'({dst_reg, srca_reg, srcb_reg, quad_mode}),
              128'({ed, en, emm, eq}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] a, b, last;
        rst_n = 1'b0; in_valid = 1'b0; wide_fmt = 1'b0; instr = '0;
        src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 reset valid", 128'(out_valid), 128'd0);
        check(result === '0, "R1 reset result", result, 128'd0);
        rst_n = 1'b1;

        // R8 R9 R10 R5: every offset, both sizes, both encoding sets
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < 16; k++) begin
                a[k*8 +: 8] = (p == 0) ? 8'(8'h10 + k) : (p == 1) ? 8'(k*37 + 5) : 8'hFF;
                b[k*8 +: 8] = (p == 0) ? 8'(8'h80 + k) : (p == 1) ? 8'(k*91 + 3) : 8'(k);
            end
            for (int w = 0; w < 2; w++) begin
                for (int q = 0; q < 2; q++) begin
                    for (int k = 0; k < 16; k++) begin
                        logic eu;
                        logic [127:0] er;
                        eu = (q == 0) && (k >= 8);
                        er = eu ? 128'h0 : ref_ext(a, b, q[0], 4'(k));
                        if (k == 0 && q == 1) check(er === a, "R10 identity model", er, a);
                        run(w[0], mk(w[0], q[0], 4'(k), 5'd2, 5'd4, 5'd6), a, b,
                            1'b1, eu, er, 5'd2, 5'd4, 5'd6, q[0],
                            q == 1 ? "R9 quad sweep" : (eu ? "R5 R6 dword undef" : "R8 R10 dword sweep"));
                    end
                end
            end
        end

        // R4 R6: register parity in 128-bit mode; R5 odd registers fine in 64-bit mode
        for (int v = 0; v < 32; v++) begin
            logic [4:0] d, n, m;
            logic eu;
            d = 5'(v); n = 5'(v + 5); m = 5'(v + 11);
            eu = d[0] | n[0] | m[0];
            run(1'b0, mk(1'b0, 1'b1, 4'd3, d, n, m), a, b, 1'b1, eu,
                eu ? 128'h0 : ref_ext(a, b, 1'b1, 4'd3), d, n, m, 1'b1, "R4 R6 parity");
            run(1'b1, mk(1'b1, 1'b0, 4'd5, d, n, m), a, b, 1'b1, 1'b0,
                ref_ext(a, b, 1'b0, 4'd5), d, n, m, 1'b0, "R5 odd regs dword");
        end

        // R2 R7: cross-set and corrupted fixed bits
        run(1'b1, mk(1'b0, 1'b1, 4'd2, 5'd0, 5'd2, 5'd4), a, b, 1'b0, 1'b0, 128'h0,
            5'd0, 5'd0, 5'd0, 1'b0, "R2 R7 fixed on wide");
        run(1'b0, mk(1'b1, 1'b1, 4'd2, 5'd0, 5'd2, 5'd4), a, b, 1'b0, 1'b0, 128'h0,
            5'd0, 5'd0, 5'd0, 1'b0, "R2 R7 wide on fixed");
        run(1'b0, mk(1'b0, 1'b1, 4'd2, 5'd0, 5'd2, 5'd4) | 32'h10, a, b, 1'b0, 1'b0,
            128'h0, 5'd0, 5'd0, 5'd0, 1'b0, "R2 R7 bit4");
        run(1'b1, mk(1'b1, 1'b0, 4'd9, 5'd1, 5'd3, 5'd5) & ~32'h0010_0000, a, b,
            1'b0, 1'b0, 128'h0, 5'd0, 5'd0, 5'd0, 1'b0, "R2 R7 bit20");
        run(1'b0, mk(1'b0, 1'b0, 4'd1, 5'd1, 5'd3, 5'd5) ^ 32'h0080_0000, a, b,
            1'b0, 1'b0, 128'h0, 5'd0, 5'd0, 5'd0, 1'b0, "R2 R7 bit23");

        // R1: outputs hold and valid drops while idle
        run(1'b0, mk(1'b0, 1'b1, 4'd7, 5'd8, 5'd10, 5'd12), a, b, 1'b1, 1'b0,
            ref_ext(a, b, 1'b1, 4'd7), 5'd8, 5'd10, 5'd12, 1'b1, "R9 before idle");
        last = result;
        instr = '0; src_a = '1; src_b = '1;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 idle valid", 128'(out_valid), 128'd0);
        check(result === last, "R1 idle hold", result, last);
        check(match === 1'b1, "R1 idle hold match", 128'(match), 128'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule